// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two 32-bit unsigned operands and a carry-in and returns a 32-bit sum with a carry-out. It has no clock and no state: the outputs follow the inputs through combinational logic only. Use it where a wide add has to finish within a single cycle and the full carry chain through 32 bits would be too slow.

The datapath is split into eight 4-bit slices. Each slice forms per-bit propagate (a XOR b) and generate (a AND b) terms. It derives its internal carries by lookahead from its own carry-in, and reports a group propagate and a group generate to the level above. A lookahead unit serves four consecutive slices, forms their carries, and forms the 16-bit section's carry-out from the group terms. The two 16-bit sections are joined end to end, so the low section's carry-out is the high section's carry-in. This is the only place where a carry passes from one unit to the next in a chain. The external carry-in enters the low section and the external carry-out leaves the high one.

Top module: `cla_adder32`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^32 for every input combination.
- R2: `cout` equals bit 32 of the full 33-bit result `a` + `b` + `cin`, including `a` = `b` = 0xFFFFFFFF with `cin` = 1, which gives `sum` = 0xFFFFFFFF and `cout` = 1.
- R3: A carry-in travels through slices whose operand bits all differ. With `a` = 0xFFFFFFFF, `b` = 0 and `cin` = 1, the result is `sum` = 0 and `cout` = 1.
- R4: A slice whose operand nibbles produce a carry by themselves passes that carry to the next slice whatever its own carry-in is. For example, `a` = 0x0000000F, `b` = 0x00000001 and `cin` = 0 give `sum` = 0x00000010.
- R5: A carry leaves the low 16-bit section (bits 15..0) and enters the high section (bits 31..16). With `a` = 0x0000FFFF, `b` = 0 and `cin` = 1, the result is `sum` = 0x00010000 and `cout` = 0.
- R6: A slice whose operand bits are both zero in every position stops an incoming carry. With `a` = 0xFF0FFFFF, `b` = 0 and `cin` = 1, the result is `sum` = 0xFF100000 and `cout` = 0.
- R7: The block holds no state. After any change of inputs the outputs depend only on the present inputs, whatever the previous inputs were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First addend |
| b | input | 32 | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of the result |
| cout | output | 1 | Carry out of bit 31 |

## Verification
The adder has no internal state, so a wrong group propagate, group generate or lookahead term shows up at once as a wrong `sum` bit or `cout` for the same inputs. The error sits at the bit position just above the faulty slice, or in the high section when the fault is in the low lookahead unit. The directed operands are chosen so that each kind of carry path is the only path that decides a visible bit: a long propagate chain, a generate inside one slice, the hand-off between sections, and a kill. A fault in any one term therefore flips a predictable output bit. Random operands then cover mixed patterns, and back-to-back operand changes show that no earlier value survives.

// File: rtl/cla_pkg.sv
// Package: shared sizing for the two-level lookahead adder.
// Assumes the datapath width divides evenly into sections and slices.
package cla_pkg;
    localparam int unsigned SLICE_BITS      = 4;   // bits per PG slice
    localparam int unsigned SLICES_PER_SECT = 4;   // slices per lookahead unit
    localparam int unsigned SECT_BITS       = SLICE_BITS * SLICES_PER_SECT;
endpackage

// File: rtl/cla_lookahead.sv
// Module: cla_lookahead
// Forms the carry into every position of a group from per-position
// propagate/generate terms and a group carry-in, as flat sums of products
// (no rippling). Output index k is the carry into position k; index N is
// the carry out of the group. Assumes N is small (a handful of positions).
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] prop_i,
    input  logic [N-1:0] gen_i,
    input  logic         cin_i,
    output logic [N:0]   carry_o
);

    // Build every carry as an OR of product terms taken directly from the inputs.
    always_comb begin
        logic acc;
        logic term;
        carry_o[0] = cin_i;
        for (int k = 1; k <= N; k++) begin
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                term = gen_i[j];
                for (int m = j + 1; m < k; m++) begin
                    term = term & prop_i[m];
                end
                acc = acc | term;
            end
            term = cin_i;
            for (int m = 0; m < k; m++) begin
                term = term & prop_i[m];
            end
            carry_o[k] = acc | term;
        end
    end

    // Check each output carry against the local generate/propagate/kill rule.
    always_comb begin
        for (int k = 1; k <= N; k++) begin
            if (gen_i[k-1]) begin
                p_carry_gen_r4: assert (carry_o[k])
                    else $error("lookahead: generate at %0d did not yield carry", k-1);
            end
            if (!gen_i[k-1] && !prop_i[k-1]) begin
                p_carry_kill_r6: assert (!carry_o[k])
                    else $error("lookahead: kill at %0d still yields carry", k-1);
            end
            if (prop_i[k-1] && !gen_i[k-1]) begin
                p_carry_pass_r3: assert (carry_o[k] == carry_o[k-1])
                    else $error("lookahead: propagate at %0d did not pass carry", k-1);
            end
        end
    end

endmodule

// File: rtl/cla_slice.sv
// Module: cla_slice
// A W-bit adder slice. It makes bit propagate/generate terms, takes its
// internal carries by lookahead from the slice carry-in, and reports a
// group propagate and generate for the level above. Assumes its carry-in
// is produced by that level.
module cla_slice #(
    parameter int unsigned W = cla_pkg::SLICE_BITS
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         grp_p_o,
    output logic         grp_g_o
);

    logic [W-1:0] bit_p;
    logic [W-1:0] bit_g;
    logic [W:0]   bit_c;

    // Per-bit propagate and generate.
    always_comb begin
        bit_p = a_i ^ b_i;
        bit_g = a_i & b_i;
    end

    cla_lookahead #(.N(W)) u_bit_la (
        .prop_i  (bit_p),
        .gen_i   (bit_g),
        .cin_i   (cin_i),
        .carry_o (bit_c)
    );

    // Sum bits from propagate and the carry into each bit.
    always_comb begin
        sum_o = bit_p ^ bit_c[W-1:0];
    end

    // Group terms: all bits propagate, or some bit generates and every bit above it propagates.
    always_comb begin
        logic term;
        grp_p_o = &bit_p;
        grp_g_o = 1'b0;
        for (int j = 0; j < W; j++) begin
            term = bit_g[j];
            for (int m = j + 1; m < W; m++) begin
                term = term & bit_p[m];
            end
            grp_g_o = grp_g_o | term;
        end
    end

    // The group terms must agree with the carry that the bit lookahead gives out of the top.
    always_comb begin
        p_grp_consistent_r3: assert ((grp_g_o | (grp_p_o & cin_i)) == bit_c[W])
            else $error("slice: group terms disagree with top carry");
    end

endmodule

// File: rtl/cla_section.sv
// Module: cla_section
// One lookahead section: S slices of W bits under one lookahead unit.
// Slice k receives the unit's carry k; the section carry-out is the
// unit's top carry. Assumes the section carry-in is already settled.
module cla_section #(
    parameter int unsigned W = cla_pkg::SLICE_BITS,
    parameter int unsigned S = cla_pkg::SLICES_PER_SECT
) (
    input  logic [W*S-1:0] a_i,
    input  logic [W*S-1:0] b_i,
    input  logic           cin_i,
    output logic [W*S-1:0] sum_o,
    output logic           cout_o
);

    localparam int unsigned SW = W * S;

    logic [S-1:0] grp_p;
    logic [S-1:0] grp_g;
    logic [S:0]   sl_c;

    cla_lookahead #(.N(S)) u_grp_la (
        .prop_i  (grp_p),
        .gen_i   (grp_g),
        .cin_i   (cin_i),
        .carry_o (sl_c)
    );

    for (genvar s = 0; s < S; s++) begin : g_slice
        cla_slice #(.W(W)) u_slice (
            .a_i     (a_i[s*W +: W]),
            .b_i     (b_i[s*W +: W]),
            .cin_i   (sl_c[s]),
            .sum_o   (sum_o[s*W +: W]),
            .grp_p_o (grp_p[s]),
            .grp_g_o (grp_g[s])
        );
    end

    // Section carry-out is the unit's top carry.
    always_comb begin
        cout_o = sl_c[S];
    end

    // The section as a whole must add correctly.
    always_comb begin
        p_section_sum_r5: assert ({cout_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{SW{1'b0}}, cin_i}))
            else $error("section: result mismatch");
    end

endmodule

// File: rtl/cla_adder32.sv
// Module: cla_adder32
// Top of the two-level lookahead adder. It chains lookahead sections end
// to end; the carry passes from one section to the next only at their
// boundary. Purely combinational. Assumes WIDTH is a multiple of the
// section width.
module cla_adder32 #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int unsigned SW    = cla_pkg::SECT_BITS;
    localparam int unsigned NSECT = WIDTH / SW;

    logic [NSECT:0] sect_c;

    // Carry into the first section comes from outside.
    always_comb begin
        sect_c[0] = cin;
    end

    for (genvar k = 0; k < NSECT; k++) begin : g_sect
        cla_section #(
            .W (cla_pkg::SLICE_BITS),
            .S (cla_pkg::SLICES_PER_SECT)
        ) u_sect (
            .a_i    (a[k*SW +: SW]),
            .b_i    (b[k*SW +: SW]),
            .cin_i  (sect_c[k]),
            .sum_o  (sum[k*SW +: SW]),
            .cout_o (sect_c[k+1])
        );
    end

    // External carry-out comes from the last section.
    always_comb begin
        cout = sect_c[NSECT];
    end

    // End-to-end result checks for the whole adder.
    always_comb begin
        logic [WIDTH:0] full;
        full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        p_sum_r1: assert (sum == full[WIDTH-1:0])
            else $error("adder: sum mismatch");
        p_cout_r2: assert (cout == full[WIDTH])
            else $error("adder: carry-out mismatch");
    end

endmodule

// File: tb/cla_adder32_tb_top.sv
// Bench for cla_adder32: directed scenarios, one task each, plus random operands.
module cla_adder32_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        cin = 1'b0;
    logic [31:0] sum;
    logic        cout;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cla_adder32 dut_i (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (!rst_n) cycles <= 0;
        else begin
            cycles <= cycles + 1;
            if (cycles > 100000 && !finished) begin
                n_errors = n_errors + 1;
                n_checks = n_checks + 1;
                $display("FAIL watchdog: actual=timeout expected=completion");
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    // Apply operands away from the clock edge, let them settle, compare to the model.
    task automatic apply_check(input string req, input logic [31:0] ta,
                               input logic [31:0] tb, input logic tc);
        logic [32:0] exp;
        @(negedge clk);
        a = ta; b = tb; cin = tc;
        #1;
        exp = {1'b0, ta} + {1'b0, tb} + {32'd0, tc};
        n_checks = n_checks + 1;
        if (sum !== exp[31:0] || cout !== exp[32]) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: a=%h b=%h cin=%0d actual=%b_%h expected=%b_%h",
                     req, ta, tb, tc, cout, sum, exp[32], exp[31:0]);
        end
    endtask

    // Exact expected values written out from the requirements.
    task automatic expect_exact(input string req, input logic [31:0] ta,
                                input logic [31:0] tb, input logic tc,
                                input logic [31:0] es, input logic ec);
        @(negedge clk);
        a = ta; b = tb; cin = tc;
        #1;
        n_checks = n_checks + 1;
        if (sum !== es || cout !== ec) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: actual=%b_%h expected=%b_%h", req, cout, sum, ec, es);
        end
    endtask

    task automatic t_zero_inputs();        // R1 R2: all-zero operands
        expect_exact("R1", 32'h0, 32'h0, 1'b0, 32'h0, 1'b0);
        expect_exact("R2", 32'h0, 32'h0, 1'b1, 32'h1, 1'b0);
    endtask

    task automatic t_extremes();           // R2: all-ones operands with carry-in
        expect_exact("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1);
        expect_exact("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE, 1'b1);
        expect_exact("R2", 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0, 1'b1);
    endtask

    task automatic t_propagate_chain();    // R3: carry runs through every slice
        expect_exact("R3", 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0, 1'b1);
        expect_exact("R3", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0, 1'b1);
        expect_exact("R3", 32'h5555_5555, 32'hAAAA_AAAA, 1'b0, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_slice_generate();     // R4: carry born inside one slice
        expect_exact("R4", 32'h0000_000F, 32'h0000_0001, 1'b0, 32'h0000_0010, 1'b0);
        expect_exact("R4", 32'h00F0_0000, 32'h0010_0000, 1'b0, 32'h0100_0000, 1'b0);
        expect_exact("R4", 32'h0000_0800, 32'h0000_0800, 1'b0, 32'h0000_1000, 1'b0);
    endtask

    task automatic t_section_cross();      // R5: carry crosses bit 15 to bit 16
        expect_exact("R5", 32'h0000_FFFF, 32'h0, 1'b1, 32'h0001_0000, 1'b0);
        expect_exact("R5", 32'h0000_8000, 32'h0000_8000, 1'b0, 32'h0001_0000, 1'b0);
        expect_exact("R5", 32'hFFFF_8000, 32'h0000_8000, 1'b0, 32'h0, 1'b1);
    endtask

    task automatic t_kill();               // R6: zero slice stops the carry
        expect_exact("R6", 32'hFF0F_FFFF, 32'h0, 1'b1, 32'hFF10_0000, 1'b0);
        expect_exact("R6", 32'hFFFF_0FFF, 32'h0, 1'b1, 32'hFFFF_1000, 1'b0);
    endtask

    task automatic t_no_memory();          // R7: outputs track only present inputs
        expect_exact("R7", 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0, 1'b1);
        expect_exact("R7", 32'h0, 32'h0, 1'b0, 32'h0, 1'b0);
        expect_exact("R7", 32'h1234_5678, 32'h0, 1'b0, 32'h1234_5678, 1'b0);
    endtask

    task automatic t_random();             // R1 R2: random operands
        for (int i = 0; i < 400; i++) begin
            apply_check("R1", $urandom, $urandom, 1'($urandom));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_zero_inputs();
        t_extremes();
        t_propagate_chain();
        t_slice_generate();
        t_section_cross();
        t_kill();
        t_no_memory();
        t_random();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule